// File: doc/BRIEF.md
# Constant On-Time Pulse Generator

This block issues the PWM request of a ripple-regulated buck controller that runs with a fixed on-time. Each clock cycle it compares a digitised feedback code against the active target. The target is the smaller of a soft-start ramp code and a reference code. When the feedback sits below that target, the block raises the PWM request for a programmed number of clock cycles and then lets it fall. The on-time count comes from upstream logic, which makes it inversely proportional to input voltage. An external timer reports when the minimum off interval after a pulse has elapsed.

Since the block only starts a pulse on a valley crossing, it never discharges an output that was pre-charged above the target: switching starts only when the feedback actually sinks below the target. The run input gates everything. When run drops, the PWM request falls within the same cycle and any pulse in progress is dropped.

Top module: `cot_pulse_gen`

## Requirements
- R1: A pulse starts at a clock edge only when run is high, `min_off_done` is high, `ton_count` is nonzero, the block is idle, and `fb_code` is strictly below the active target, with all codes compared as unsigned. `pwm_req` is high in the cycle after that edge.
- R2: The active target is the smaller of `ss_code` and `ref_code`. A feedback code between the two values never starts a pulse.
- R3: Once started, `pwm_req` stays high for exactly `ton_count` clock cycles.
- R4: When `fb_code` is equal to or above the active target, no pulse is issued (pre-biased output left untouched).
- R5: While `min_off_done` is low, no pulse starts. A trigger still present when `min_off_done` rises gives `pwm_req` high after the next clock edge.
- R6: The on-time is captured when the pulse starts. Changing `ton_count` during a pulse does not change that pulse's length.
- R7: When run is low, `pwm_req` is low in the same cycle and any pulse in progress is aborted. When run returns, no pulse appears without a new trigger.
- R8: A `ton_count` of zero never starts a pulse.
- R9: During and after reset, `pwm_req` is low until a trigger occurs.
- R10: Under a continuous trigger, consecutive pulses are separated by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable; low forces the request low and aborts a pulse |
| fb_code | input | CODE_W | Digitised feedback |
| ss_code | input | CODE_W | Soft-start ramp code |
| ref_code | input | CODE_W | Reference code |
| ton_count | input | TON_W | On-time in clock cycles |
| min_off_done | input | 1 | High when the minimum off interval has elapsed |
| pwm_req | output | 1 | PWM request to the gate driver |

## Verification
The bench sweeps every combination of feedback, soft-start and reference codes in a 4-bit configuration. This catches a design that compares against the larger target, uses a non-strict comparison, or switches into a pre-biased output. It measures each on-time from 1 to 7 and changes the count in mid-pulse, which exposes an off-by-one counter or a counter that is not latched. Further cases cover holding off the minimum off interval, dropping run in mid-pulse, and a zero on-time. These expose a design that fires too early, delays the abort to the next edge, restarts on its own, or emits a zero-length glitch.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic {
    ST_OFF = 1'b0,
    ST_ON  = 1'b1
  } cot_state_e;
endpackage

// File: rtl/cot_target_sel.sv
module cot_target_sel #(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] ss_code,
  input  logic [CODE_W-1:0] ref_code,
  output logic [CODE_W-1:0] target
);
  // Soft-start ramp governs until it passes the reference.
  always_comb begin
    if (ss_code < ref_code) target = ss_code;
    else                    target = ref_code;
  end
endmodule

// File: rtl/cot_trigger.sv
module cot_trigger #(
  parameter int CODE_W = 10
) (
  input  logic              run,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] target,
  output logic              trig
);
  // Valley detect: strictly below the target.
  always_comb trig = run && (fb_code < target);
endmodule

// File: rtl/cot_ontimer.sv
module cot_ontimer #(
  parameter int TON_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [TON_W-1:0] ton,
  output logic             last,
  output logic             busy
);
  logic [TON_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (abort) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      cnt_d  = ton;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == {{(TON_W-1){1'b0}}, 1'b1});
  assign busy = (cnt_q != '0);

  // R6: a running pulse counts down by one, whatever the ton input does.
  assert_latched_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > 1 && !abort && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cot_pulse_gen.sv
module cot_pulse_gen #(
  parameter int CODE_W = 10,
  parameter int TON_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ss_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [TON_W-1:0]  ton_count,
  input  logic              min_off_done,
  output logic              pwm_req
);
  import cot_pkg::*;

  logic [CODE_W-1:0] target;
  logic              trig;
  logic              start;
  logic              t_last;
  logic              t_busy;
  logic              pwm_on;
  cot_state_e        state_q, state_d;

  cot_target_sel #(.CODE_W(CODE_W)) i_sel (
    .ss_code (ss_code),
    .ref_code(ref_code),
    .target  (target)
  );

  cot_trigger #(.CODE_W(CODE_W)) i_trig (
    .run    (run),
    .fb_code(fb_code),
    .target (target),
    .trig   (trig)
  );

  assign start = (state_q == ST_OFF) && trig && min_off_done && (ton_count != '0);

  cot_ontimer #(.TON_W(TON_W)) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (start),
    .abort(!run),
    .ton  (ton_count),
    .last (t_last),
    .busy (t_busy)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF: if (start) state_d = ST_ON;
      ST_ON:  if (!run || t_last) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign pwm_on  = (state_q == ST_ON);
  assign pwm_req = pwm_on && run;

  // R1 R2: a pulse begins only after feedback was under both codes.
  assert_start_below_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_on) |-> $past(fb_code < ss_code && fb_code < ref_code && run));
  // R5: the minimum off interval had finished.
  assert_min_off_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_on) |-> $past(min_off_done));
  // R8: zero on-time never starts a pulse.
  assert_zero_ton_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_on) |-> ($past(ton_count) != '0));
  // R7: dropping run ends the pulse at the next edge.
  assert_run_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_on);
  // R3: the high phase is always backed by a loaded timer.
  assert_timer_backs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_on |-> t_busy);
endmodule

// File: tb/test_cot_pulse_gen.sv
module test_cot_pulse_gen;
  localparam int CW = 4;
  localparam int TW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic [CW-1:0] fb_code, ss_code, ref_code;
  logic [TW-1:0] ton_count;
  logic          min_off_done;
  logic          pwm_req;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cot_pulse_gen #(.CODE_W(CW), .TON_W(TW)) i_cot_pulse_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .fb_code(fb_code), .ss_code(ss_code),
    .ref_code(ref_code), .ton_count(ton_count), .min_off_done(min_off_done),
    .pwm_req(pwm_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic no_trig();
    @(negedge clk);
    fb_code = CW'(CMAX); ss_code = '0; ref_code = '0;
  endtask

  task automatic drive_trig(input int ton);
    @(negedge clk);
    fb_code = '0; ss_code = CW'(CMAX); ref_code = CW'(CMAX); ton_count = TW'(ton);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b1; min_off_done = 1'b1; ton_count = TW'(1);
    fb_code = '0; ss_code = CW'(CMAX); ref_code = CW'(CMAX);
    #1;
    tick(); tick();
    chk("R9 in reset", int'(pwm_req), 0);
    no_trig();
    rst_n = 1'b1;
    tick(); tick();
    chk("R9 after reset", int'(pwm_req), 0);

    // R1 R2 R4: exhaustive sweep with ton of one
    for (int f = 0; f <= CMAX; f++)
      for (int s = 0; s <= CMAX; s++)
        for (int r = 0; r <= CMAX; r++) begin
          int lo;
          @(negedge clk);
          fb_code = CW'(f); ss_code = CW'(s); ref_code = CW'(r); ton_count = TW'(1);
          tick();
          lo = (s < r) ? s : r;
          chk((f < lo) ? "R1 R2 start" : "R4 R2 hold", int'(pwm_req), (f < lo) ? 1 : 0);
          no_trig();
          tick();
        end

    // R3: pulse length for every nonzero on-time
    for (int n = 1; n < (1 << TW); n++) begin
      int cnt;
      cnt = 0;
      drive_trig(n);
      tick();
      if (pwm_req) cnt++;
      no_trig();
      for (int k = 0; k < 12; k++) begin
        tick();
        if (pwm_req) cnt++;
      end
      chk("R3 pulse length", cnt, n);
    end

    // R6: changing ton mid-pulse does not alter it
    begin
      int cnt;
      cnt = 0;
      drive_trig(5);
      tick();
      if (pwm_req) cnt++;
      no_trig();
      ton_count = TW'(2);
      for (int k = 0; k < 12; k++) begin
        tick();
        if (pwm_req) cnt++;
      end
      chk("R6 latched on-time", cnt, 5);
    end

    // R5: min off hold-off, then start on the next edge
    @(negedge clk);
    min_off_done = 1'b0;
    drive_trig(2);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 held off", int'(pwm_req), 0);
    end
    @(negedge clk);
    min_off_done = 1'b1;
    tick();
    chk("R5 start after off", int'(pwm_req), 1);
    tick();
    chk("R3 second cycle", int'(pwm_req), 1);
    // R10: continuous trigger gives one low gap
    tick();
    chk("R10 gap", int'(pwm_req), 0);
    tick();
    chk("R10 next pulse", int'(pwm_req), 1);
    no_trig();
    tick(); tick(); tick();

    // R7: run drop aborts at once
    drive_trig(6);
    tick(); tick();
    chk("R7 pulse running", int'(pwm_req), 1);
    @(negedge clk);
    run = 1'b0;
    #1;
    chk("R7 immediate low", int'(pwm_req), 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 held low", int'(pwm_req), 0);
    end
    no_trig();
    run = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 no resume", int'(pwm_req), 0);
    end

    // R8: zero on-time
    drive_trig(0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R8 zero on-time", int'(pwm_req), 0);
    end
    no_trig();
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule